// File: doc/BRIEF.md
# Dual-Bank Serial Control Latch

This block is the serial data front end of a multi-channel LED driver. A frame of 769 bits is clocked in one bit per shift cycle and moves up a single common register. The top bit of that register is always visible on a serial output, so several devices can be daisy-chained. A rising edge on the latch strobe moves the register contents into one of two banks. Which bank is chosen depends on the top bit of the frame.

When the top bit is 0, the frame is a grayscale frame. Its lower 768 bits (48 channels of 16 bits) go into the grayscale bank. At the same moment, the staged per-channel correction values become active. When the top bit is 1, the frame is a control frame. It is accepted only if the eight bits just below the top hold the write key 0x96. An accepted control frame loads the brightness and function fields straight away. It places the per-channel correction values in a staging store. It changes the current-limit field only after two accepted control frames in a row carry the same value.

All banks are exposed as parallel outputs. The PWM engine, the output drivers and fault detection are outside this block. The block runs from one clock. Shifting is qualified by `shift_i`, and the strobe is edge-detected in the same clock domain.

Top module: `serial_ctrl_latch`

## Requirements
- R1: While `shift_i` is high on a rising clock edge, `sin_i` enters bit 0 and every other bit moves up by one place. A bit entered first reaches bit 768 after exactly 769 shifts.
- R2: `sout_o` always equals bit 768 of the common register.
- R3: A transfer happens only in the cycle where `lat_i` is first seen high after being low. Holding `lat_i` high causes no further transfer, even if new data is shifted in meanwhile.
- R4: On a transfer with bit 768 = 0, `gs_o` takes bits 767:0. It changes at no other time.
- R5: The same grayscale transfer copies the staged correction store into `dc_o`. `dc_o` changes at no other time.
- R6: On a transfer with bit 768 = 1 and bits 767:760 = 0x96, bits 335:0 go into the staging store only. `dc_o` keeps its value.
- R7: On such an accepted control transfer, `bc_o` takes bits 365:345 and `fc_o` takes bits 370:366.
- R8: `mc_o` takes bits 344:336 only on an accepted control transfer whose value equals that of the previous accepted control transfer, provided no rejected control transfer came between them. Grayscale transfers in between do not break the pairing.
- R9: A control transfer whose key bits 767:760 differ from 0x96 changes no output. It also discards the pending current-limit value, so two fresh matching writes are needed afterwards.
- R10: A control transfer of any key leaves `gs_o` unchanged.
- R11: A synchronous active-high `rst` clears the common register, all output banks, the staging store and the pending current-limit record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_i | input | 1 | Shift qualifier for the common register |
| sin_i | input | 1 | Serial data entering bit 0 |
| lat_i | input | 1 | Latch strobe, acted on at its rising edge |
| sout_o | output | 1 | Top bit of the common register |
| gs_o | output | 768 | Grayscale bank, 16 bits per channel |
| dc_o | output | 336 | Active correction bank, 7 bits per channel |
| mc_o | output | 9 | Current-limit field |
| bc_o | output | 21 | Brightness field |
| fc_o | output | 5 | Function field |

## Verification
The bench separates the staging of correction values from their activation. A design that drove `dc_o` directly on a control frame would show new values one grayscale frame too early. The current-limit pairing is exercised in four ways: matching writes with a grayscale frame between them, mismatched values, a rejected key between two matching writes, and a reset between two matching writes. A design that accepted single writes, or kept its pending record across a rejection, would move `mc_o` at the wrong frame. Holding the strobe high while a new frame is shifted in catches level-sensitive latching. A single marker bit walked through the register checks the length of the serial path and the output tap.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;

    localparam int CH       = 48;
    localparam int GS_W     = 16;
    localparam int DC_W     = 7;
    localparam int MC_W     = 9;
    localparam int BC_W     = 21;
    localparam int FC_W     = 5;
    localparam int KEY_W    = 8;
    localparam logic [KEY_W-1:0] WRITE_KEY = 8'h96;

    localparam int GS_TOT   = CH * GS_W;
    localparam int DC_TOT   = CH * DC_W;
    localparam int SR_W     = GS_TOT + 1;
    localparam int SEL_BIT  = SR_W - 1;
    localparam int KEY_LSB  = GS_TOT - KEY_W;
    localparam int MC_LSB   = DC_TOT;
    localparam int BC_LSB   = MC_LSB + MC_W;
    localparam int FC_LSB   = BC_LSB + BC_W;

    typedef enum logic [1:0] {
        XFER_NONE   = 2'd0,
        XFER_GRAY   = 2'd1,
        XFER_CTRL   = 2'd2,
        XFER_REJECT = 2'd3
    } xfer_e;

    typedef struct packed {
        logic [FC_W-1:0]   fc;
        logic [BC_W-1:0]   bc;
        logic [MC_W-1:0]   mc;
        logic [DC_TOT-1:0] dc;
    } ctrl_fields_t;

    function automatic xfer_e classify(input logic strobe_edge,
                                       input logic sel,
                                       input logic [KEY_W-1:0] key);
        if (!strobe_edge)          return XFER_NONE;
        else if (!sel)             return XFER_GRAY;
        else if (key == WRITE_KEY) return XFER_CTRL;
        else                       return XFER_REJECT;
    endfunction

endpackage

// File: rtl/ctl_latch_shift.sv
module ctl_latch_shift
    import ctl_latch_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_i,
    input  logic            sin_i,
    output logic [SR_W-1:0] sr_o
);

    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (shift_i) begin
            sr_q <= {sr_q[SR_W-2:0], sin_i};
        end
    end

    assign sr_o = sr_q;

endmodule

// File: rtl/ctl_latch_decode.sv
module ctl_latch_decode
    import ctl_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lat_i,
    input  logic [SR_W-1:0]   sr_i,
    output xfer_e             xfer_o,
    output ctrl_fields_t      fields_o,
    output logic [GS_TOT-1:0] gray_o
);

    logic lat_q;
    logic lat_edge;

    always_ff @(posedge clk) begin
        if (rst) lat_q <= 1'b0;
        else     lat_q <= lat_i;
    end

    assign lat_edge = lat_i & ~lat_q;

    always_comb begin
        xfer_o      = classify(lat_edge, sr_i[SEL_BIT], sr_i[KEY_LSB +: KEY_W]);
        fields_o.dc = sr_i[0 +: DC_TOT];
        fields_o.mc = sr_i[MC_LSB +: MC_W];
        fields_o.bc = sr_i[BC_LSB +: BC_W];
        fields_o.fc = sr_i[FC_LSB +: FC_W];
        gray_o      = sr_i[0 +: GS_TOT];
    end

endmodule

// File: rtl/ctl_latch_ctrl_bank.sv
module ctl_latch_ctrl_bank
    import ctl_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  xfer_e             xfer_i,
    input  ctrl_fields_t      fields_i,
    output logic [DC_TOT-1:0] stage_o,
    output logic [MC_W-1:0]   mc_o,
    output logic [BC_W-1:0]   bc_o,
    output logic [FC_W-1:0]   fc_o
);

    logic            accept;
    logic [MC_W-1:0] mc_pend_q;
    logic            mc_pend_vld_q;
    logic            mc_pair;

    assign accept  = (xfer_i == XFER_CTRL);
    assign mc_pair = mc_pend_vld_q && (mc_pend_q == fields_i.mc);

    for (genvar ch = 0; ch < CH; ch++) begin : g_stage
        logic [DC_W-1:0] stage_q;
        always_ff @(posedge clk) begin
            if (rst)         stage_q <= '0;
            else if (accept) stage_q <= fields_i.dc[ch*DC_W +: DC_W];
        end
        assign stage_o[ch*DC_W +: DC_W] = stage_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bc_o <= '0;
            fc_o <= '0;
        end else if (accept) begin
            bc_o <= fields_i.bc;
            fc_o <= fields_i.fc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_o          <= '0;
            mc_pend_q     <= '0;
            mc_pend_vld_q <= 1'b0;
        end else begin
            unique case (xfer_i)
                XFER_CTRL: begin
                    if (mc_pair) mc_o <= fields_i.mc;
                    mc_pend_q     <= fields_i.mc;
                    mc_pend_vld_q <= 1'b1;
                end
                XFER_REJECT: mc_pend_vld_q <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctl_latch_gray_bank.sv
module ctl_latch_gray_bank
    import ctl_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  xfer_e             xfer_i,
    input  logic [GS_TOT-1:0] gray_i,
    input  logic [DC_TOT-1:0] stage_i,
    output logic [GS_TOT-1:0] gs_o,
    output logic [DC_TOT-1:0] dc_o
);

    logic load;
    assign load = (xfer_i == XFER_GRAY);

    for (genvar ch = 0; ch < CH; ch++) begin : g_chan
        logic [GS_W-1:0] gs_q;
        logic [DC_W-1:0] dc_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                gs_q <= '0;
                dc_q <= '0;
            end else if (load) begin
                gs_q <= gray_i[ch*GS_W +: GS_W];
                dc_q <= stage_i[ch*DC_W +: DC_W];
            end
        end
        assign gs_o[ch*GS_W +: GS_W] = gs_q;
        assign dc_o[ch*DC_W +: DC_W] = dc_q;
    end

endmodule

// File: rtl/serial_ctrl_latch.sv
module serial_ctrl_latch
    import ctl_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_i,
    input  logic              sin_i,
    input  logic              lat_i,
    output logic              sout_o,
    output logic [GS_TOT-1:0] gs_o,
    output logic [DC_TOT-1:0] dc_o,
    output logic [MC_W-1:0]   mc_o,
    output logic [BC_W-1:0]   bc_o,
    output logic [FC_W-1:0]   fc_o
);

    logic [SR_W-1:0]   sr_q;
    xfer_e             xfer;
    ctrl_fields_t      fields;
    logic [GS_TOT-1:0] gray;
    logic [DC_TOT-1:0] stage;

    ctl_latch_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_i (shift_i),
        .sin_i   (sin_i),
        .sr_o    (sr_q)
    );

    ctl_latch_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .lat_i    (lat_i),
        .sr_i     (sr_q),
        .xfer_o   (xfer),
        .fields_o (fields),
        .gray_o   (gray)
    );

    ctl_latch_ctrl_bank u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .xfer_i   (xfer),
        .fields_i (fields),
        .stage_o  (stage),
        .mc_o     (mc_o),
        .bc_o     (bc_o),
        .fc_o     (fc_o)
    );

    ctl_latch_gray_bank u_gray (
        .clk     (clk),
        .rst     (rst),
        .xfer_i  (xfer),
        .gray_i  (gray),
        .stage_i (stage),
        .gs_o    (gs_o),
        .dc_o    (dc_o)
    );

    assign sout_o = sr_q[SEL_BIT];

endmodule

// File: rtl/serial_ctrl_latch_chk.sv
module serial_ctrl_latch_chk
    import ctl_latch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              shift_i,
    input logic              lat_i,
    input logic [KEY_W:0]    top,
    input logic              sout_o,
    input logic [GS_TOT-1:0] gs_o,
    input logic [DC_TOT-1:0] dc_o,
    input logic [MC_W-1:0]   mc_o,
    input logic [BC_W-1:0]   bc_o,
    input logic [FC_W-1:0]   fc_o
);

    logic lat_d;
    logic rise;
    logic ok_ctrl;
    logic gray_ev;

    always_ff @(posedge clk) begin
        if (rst) lat_d <= 1'b0;
        else     lat_d <= lat_i;
    end

    assign rise    = lat_i && !lat_d;
    assign ok_ctrl = rise && top[KEY_W] && (top[KEY_W-1:0] == WRITE_KEY);
    assign gray_ev = rise && !top[KEY_W];

    AST_SOUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (sout_o == $past(top[KEY_W-1]))); // R2

    AST_GS_ONLY_ON_GRAY: assert property (@(posedge clk) disable iff (rst)
        !gray_ev |=> $stable(gs_o)); // R4

    AST_DC_ONLY_ON_GRAY: assert property (@(posedge clk) disable iff (rst)
        !gray_ev |=> $stable(dc_o)); // R5

    AST_BC_ONLY_ON_CTRL: assert property (@(posedge clk) disable iff (rst)
        !ok_ctrl |=> $stable(bc_o)); // R7

    AST_FC_ONLY_ON_CTRL: assert property (@(posedge clk) disable iff (rst)
        !ok_ctrl |=> $stable(fc_o)); // R7

    AST_MC_ONLY_ON_CTRL: assert property (@(posedge clk) disable iff (rst)
        !ok_ctrl |=> $stable(mc_o)); // R8

    AST_GS_KEPT_ON_CTRL: assert property (@(posedge clk) disable iff (rst)
        (rise && top[KEY_W]) |=> $stable(gs_o)); // R10

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (gs_o == '0 && dc_o == '0 && mc_o == '0 && bc_o == '0 && fc_o == '0 && !sout_o)); // R11

endmodule

bind serial_ctrl_latch serial_ctrl_latch_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .shift_i (shift_i),
    .lat_i   (lat_i),
    .top     (sr_q[SEL_BIT:KEY_LSB]),
    .sout_o  (sout_o),
    .gs_o    (gs_o),
    .dc_o    (dc_o),
    .mc_o    (mc_o),
    .bc_o    (bc_o),
    .fc_o    (fc_o)
);

// File: tb/serial_ctrl_latch_tb.sv
module serial_ctrl_latch_tb;

    logic clk = 1'b0;
    logic rst, shift_i, sin_i, lat_i;
    logic         sout_o;
    logic [767:0] gs_o;
    logic [335:0] dc_o;
    logic [8:0]   mc_o;
    logic [20:0]  bc_o;
    logic [4:0]   fc_o;

    always #4 clk = ~clk;

    serial_ctrl_latch u_dut (
        .clk(clk), .rst(rst), .shift_i(shift_i), .sin_i(sin_i), .lat_i(lat_i),
        .sout_o(sout_o), .gs_o(gs_o), .dc_o(dc_o), .mc_o(mc_o), .bc_o(bc_o), .fc_o(fc_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [767:0] e_gs;
    logic [335:0] e_dc, e_stage;
    logic [8:0]   e_mc, e_pend;
    logic         e_pvld;
    logic [20:0]  e_bc;
    logic [4:0]   e_fc;

    typedef struct packed {
        logic        ctrl;
        logic [7:0]  key;
        logic [8:0]  mc;
        logic [20:0] bc;
        logic [4:0]  fc;
        logic [15:0] seed;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 9'h000, 21'h000000, 5'h00, 16'hA5C3},
        '{1'b1, 8'h96, 9'h1AB, 21'h1F00F1, 5'h15, 16'h1234},
        '{1'b0, 8'h00, 9'h000, 21'h000000, 5'h00, 16'h0F0F},
        '{1'b1, 8'h96, 9'h1AB, 21'h0ABCDE, 5'h0A, 16'h5678},
        '{1'b1, 8'h96, 9'h055, 21'h155555, 5'h1F, 16'h9ABC},
        '{1'b1, 8'h69, 9'h055, 21'h0AAAAA, 5'h01, 16'hDEF0},
        '{1'b1, 8'h96, 9'h055, 21'h012345, 5'h02, 16'h3C3C},
        '{1'b1, 8'h96, 9'h055, 21'h054321, 5'h04, 16'hC3C3},
        '{1'b1, 8'h96, 9'h0F0, 21'h1FFFFF, 5'h08, 16'h7E81},
        '{1'b0, 8'h00, 9'h000, 21'h000000, 5'h00, 16'h8001}
    };

    function automatic logic [768:0] make_frame(input vec_t v);
        logic [767:0] base = {48{v.seed}};
        logic [768:0] f;
        if (!v.ctrl) begin
            f = {1'b0, base};
        end else begin
            f = {1'b1, v.key, base[759:0]};
            f[370:366] = v.fc;
            f[365:345] = v.bc;
            f[344:336] = v.mc;
        end
        return f;
    endfunction

    task automatic check(input string req, input logic [767:0] act, input logic [767:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string ctx);
        check({ctx, " R4 R10 gs"}, gs_o, e_gs);
        check({ctx, " R5 R6 dc"}, {432'd0, dc_o}, {432'd0, e_dc});
        check({ctx, " R8 R9 mc"}, {759'd0, mc_o}, {759'd0, e_mc});
        check({ctx, " R7 R9 bc"}, {747'd0, bc_o}, {747'd0, e_bc});
        check({ctx, " R7 R9 fc"}, {763'd0, fc_o}, {763'd0, e_fc});
    endtask

    task automatic model_clear();
        e_gs = '0; e_dc = '0; e_stage = '0; e_mc = '0; e_pend = '0;
        e_pvld = 1'b0; e_bc = '0; e_fc = '0;
    endtask

    task automatic model_apply(input logic [768:0] f);
        if (!f[768]) begin
            e_gs = f[767:0];
            e_dc = e_stage;
        end else if (f[767:760] == 8'h96) begin
            e_stage = f[335:0];
            if (e_pvld && e_pend == f[344:336]) e_mc = f[344:336];
            e_pend = f[344:336];
            e_pvld = 1'b1;
            e_bc   = f[365:345];
            e_fc   = f[370:366];
        end else begin
            e_pvld = 1'b0;
        end
    endtask

    task automatic shift_frame(input logic [768:0] f);
        for (int k = 768; k >= 0; k--) begin
            @(negedge clk);
            shift_i = 1'b1;
            sin_i   = f[k];
        end
        @(negedge clk);
        shift_i = 1'b0;
        sin_i   = 1'b0;
    endtask

    task automatic pulse_lat();
        @(negedge clk);
        lat_i = 1'b1;
        @(negedge clk);
        lat_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [768:0] f;
        rst = 1'b1; shift_i = 1'b0; sin_i = 1'b0; lat_i = 1'b0;
        model_clear();
        do_reset();

        // R11: reset state
        check_outputs("reset");
        check("R11 R2 sout after reset", {767'd0, sout_o}, 768'd0);

        // R1 / R2: marker bit walks the full register length
        @(negedge clk); shift_i = 1'b1; sin_i = 1'b1;
        for (int k = 0; k < 767; k++) begin
            @(negedge clk); sin_i = 1'b0;
        end
        @(negedge clk); shift_i = 1'b0;
        check("R1 after 768 shifts", {767'd0, sout_o}, 768'd0);
        @(negedge clk); shift_i = 1'b1; sin_i = 1'b0;
        @(negedge clk); shift_i = 1'b0;
        check("R1 R2 after 769 shifts", {767'd0, sout_o}, 768'd1);
        @(negedge clk); shift_i = 1'b1;
        @(negedge clk); shift_i = 1'b0;
        check("R2 after 770 shifts", {767'd0, sout_o}, 768'd0);

        // Vector table: grayscale, control, rejected key, MC pairing
        for (int i = 0; i < NV; i++) begin
            f = make_frame(VEC[i]);
            shift_frame(f);
            check($sformatf("vec%0d R2 sout", i), {767'd0, sout_o}, {767'd0, f[768]});
            pulse_lat();
            model_apply(f);
            check_outputs($sformatf("vec%0d", i));
        end

        // R3: strobe held high, new frame shifted in, no second transfer
        @(negedge clk); lat_i = 1'b1;
        @(negedge clk);
        f = make_frame('{1'b0, 8'h00, 9'h000, 21'h0, 5'h0, 16'h4242});
        shift_frame(f);
        check("R3 held strobe gs", gs_o, e_gs);
        @(negedge clk); lat_i = 1'b0;
        @(negedge clk);
        check("R3 strobe fall gs", gs_o, e_gs);
        pulse_lat();
        model_apply(f);
        check("R3 R4 fresh edge gs", gs_o, e_gs);

        // R11: reset mid-stream clears staging and pending MC record
        f = make_frame('{1'b1, 8'h96, 9'h133, 21'h13579, 5'h11, 16'hBEEF});
        shift_frame(f);
        pulse_lat();
        model_apply(f);
        check_outputs("pre-reset");
        do_reset();
        check_outputs("R11 mid reset");
        shift_frame(make_frame('{1'b0, 8'h00, 9'h000, 21'h0, 5'h0, 16'h1111}));
        pulse_lat();
        model_apply(make_frame('{1'b0, 8'h00, 9'h000, 21'h0, 5'h0, 16'h1111}));
        check("R11 staged dc cleared", {432'd0, dc_o}, 768'd0);
        f = make_frame('{1'b1, 8'h96, 9'h133, 21'h2468A, 5'h12, 16'hCAFE});
        shift_frame(f);
        pulse_lat();
        model_apply(f);
        check("R11 R8 pending cleared mc", {759'd0, mc_o}, 768'd0);
        check_outputs("post-reset ctrl");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule